// File: doc/BRIEF.md
# Coprocessor Load/Store Instruction Classifier

This block looks at one 32-bit instruction word per clock and decides whether it belongs to the coprocessor load/store encoding group. For words in that group it names the outcome with a single class code:
- an ordinary register-based load or store;
- a PC-relative (literal) load;
- a redirect to the two-register coprocessor transfer decoder;
- a redirect to the vector/floating-point decoder;
- an undefined encoding.

It also splits out every operand field and reports whether the word is the unconditional form, the one whose condition field is all ones. Words from any other group get a neutral "other" class.

The conditional and unconditional forms share one field layout. They differ only for coprocessors 10 and 11: the conditional form hands those to the vector/FP decoder, and the unconditional form treats them as undefined. Reserved coprocessor numbers are undefined in both forms.

The result is registered, with one cycle of latency from the input strobe. A downstream decode stage uses the class code to steer the word, and uses the split fields without decoding them again.

Top module: `cpls_classifier`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. It is low while `rst_n` is low.
- R2: For a captured word, the fields come from these bits:
  - `out_imm` from bits [7:0];
  - `out_cop` from bits [11:8];
  - `out_creg` from bits [15:12];
  - `out_base` from bits [19:16];
  - `out_wb` from bit 21;
  - `out_long` from bit 22;
  - `out_up` from bit 23;
  - `out_pre` from bit 24.
- R3: `out_v2` is 1 exactly when bits [31:28] of the captured word are 4'b1111.
- R4: A word whose bits [27:25] are not 3'b110 gives class 0 (other), with `out_undef` and `out_literal` both 0.
- R5: In the group, a word with bits [24:21] = 4'b0000 gives class 5 (undefined) and `out_undef`=1, whatever its coprocessor number or base register.
- R6: In the group, a word with bits [24:21] = 4'b0010 gives class 3 (two-register transfer redirect), whatever its coprocessor number.
- R7: If R5 and R6 do not apply and the coprocessor number is 10 or 11, the class depends on the form:
  - the conditional form gives class 4 (vector/FP redirect) with `out_undef`=0;
  - the unconditional form gives class 5 with `out_undef`=1.
- R8: If R5 to R7 do not apply and the coprocessor number is 8, 9, 12 or 13, the class is 5 and `out_undef`=1.
- R9: If R5 to R8 do not apply, the class depends on the load bit (bit 20) and the base register:
  - a load (bit 20 = 1) with base register 4'b1111 gives class 2 with `out_literal`=1;
  - any other word gives class 1 (register-based load/store) with `out_literal`=0. This includes a store with base register 4'b1111.
- R10: `out_load` equals bit 20 of the captured word.
- R11: Word 0xFD910A01 decodes as follows: v2=1, P=1, U=1, D=0, W=0, load=1, base=1, CRd=0, coproc=10, imm=1, class 5, `out_undef`=1.
- R12: `out_undef` is 1 exactly when the class is 5, and `out_literal` is 1 exactly when the class is 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Instruction word present this cycle |
| in_insn | input | 32 | Instruction word |
| out_valid | output | 1 | Registered result valid |
| out_class | output | 3 | Class code (0 other, 1 register-based load/store, 2 literal, 3 two-register redirect, 4 vector/FP redirect, 5 undefined) |
| out_v2 | output | 1 | Unconditional form (condition field all ones) |
| out_load | output | 1 | 1 = load, 0 = store |
| out_literal | output | 1 | PC-relative load form |
| out_undef | output | 1 | Undefined encoding |
| out_pre | output | 1 | Pre-index bit |
| out_up | output | 1 | Add-offset bit |
| out_long | output | 1 | Long-transfer bit |
| out_wb | output | 1 | Write-back bit |
| out_base | output | 4 | Base register number |
| out_creg | output | 4 | Coprocessor register number |
| out_cop | output | 4 | Coprocessor number |
| out_imm | output | 8 | 8-bit immediate offset |

## Verification
The bench builds the classifier with its defaults: 4-bit condition, register and coprocessor fields, an 8-bit immediate, group code 3'b110, and reserved and vector/FP masks for coprocessors {8,9,12,13} and {10,11}. It uses the synchronous-reset variant. With a 4-bit coprocessor field, all sixteen coprocessor numbers can be reached, so every rule of the priority chain can be hit from both condition forms. The random stimulus is biased toward the group code, toward the two special P/U/D/W patterns and toward an all-ones base register, so that the literal-versus-store split and the ordering of the priority rules are exercised often.

// File: rtl/cpls_pkg.sv
package cpls_pkg;
   localparam int CLS_W = 3;

   typedef enum logic [CLS_W-1:0] {
      CLS_OTHER = 3'd0,
      CLS_MEM   = 3'd1,
      CLS_LIT   = 3'd2,
      CLS_XFER2 = 3'd3,
      CLS_VEC   = 3'd4,
      CLS_UNDEF = 3'd5
   } cpls_cls_e;

   localparam logic [3:0] PUDW_NONE  = 4'b0000;
   localparam logic [3:0] PUDW_XFER2 = 4'b0010;
endpackage

// File: rtl/cpls_field_split.sv
module cpls_field_split #(
   parameter int         COND_W     = 4,
   parameter int         REG_W      = 4,
   parameter int         COP_W      = 4,
   parameter int         IMM_W      = 8,
   parameter logic [2:0] GROUP_CODE = 3'b110,
   localparam int        COP_LSB    = IMM_W,
   localparam int        CRD_LSB    = COP_LSB + COP_W,
   localparam int        RN_LSB     = CRD_LSB + REG_W,
   localparam int        L_BIT      = RN_LSB + REG_W,
   localparam int        W_BIT      = L_BIT + 1,
   localparam int        D_BIT      = L_BIT + 2,
   localparam int        U_BIT      = L_BIT + 3,
   localparam int        P_BIT      = L_BIT + 4,
   localparam int        GRP_LSB    = P_BIT + 1,
   localparam int        COND_LSB   = GRP_LSB + 3,
   localparam int        INSN_W     = COND_LSB + COND_W
) (
   input  logic [INSN_W-1:0] insn,
   output logic              in_group,
   output logic              is_v2,
   output logic              pre,
   output logic              up,
   output logic              lng,
   output logic              wb,
   output logic              load,
   output logic [REG_W-1:0]  base,
   output logic [REG_W-1:0]  creg,
   output logic [COP_W-1:0]  cop,
   output logic [IMM_W-1:0]  imm
);
   assign is_v2    = &insn[COND_LSB +: COND_W];
   assign in_group = (insn[GRP_LSB +: 3] == GROUP_CODE);
   assign pre      = insn[P_BIT];
   assign up       = insn[U_BIT];
   assign lng      = insn[D_BIT];
   assign wb       = insn[W_BIT];
   assign load     = insn[L_BIT];
   assign base     = insn[RN_LSB +: REG_W];
   assign creg     = insn[CRD_LSB +: REG_W];
   assign cop      = insn[COP_LSB +: COP_W];
   assign imm      = insn[IMM_W-1:0];
endmodule

// File: rtl/cpls_cop_rules.sv
module cpls_cop_rules #(
   parameter int COP_W  = 4,
   localparam int N_COP = 1 << COP_W,
   parameter logic [N_COP-1:0] RSVD_MASK = 16'h3300,
   parameter logic [N_COP-1:0] VEC_MASK  = 16'h0C00
) (
   input  logic [COP_W-1:0] cop,
   output logic             cop_vec,
   output logic             cop_rsvd
);
   logic [N_COP-1:0] hit;

   for (genvar i = 0; i < N_COP; i++) begin : g_hit
      assign hit[i] = (cop == COP_W'(i));
   end

   assign cop_vec  = |(hit & VEC_MASK);
   assign cop_rsvd = |(hit & RSVD_MASK);
endmodule

// File: rtl/cpls_class_pick.sv
module cpls_class_pick
   import cpls_pkg::*;
(
   input  logic       in_group,
   input  logic       is_v2,
   input  logic [3:0] pudw,
   input  logic       load,
   input  logic       base_all1,
   input  logic       cop_vec,
   input  logic       cop_rsvd,
   output cpls_cls_e  cls
);
   always_comb begin
      if (!in_group)               cls = CLS_OTHER;
      else if (pudw == PUDW_NONE)  cls = CLS_UNDEF;
      else if (pudw == PUDW_XFER2) cls = CLS_XFER2;
      else if (cop_vec)            cls = is_v2 ? CLS_UNDEF : CLS_VEC;
      else if (cop_rsvd)           cls = CLS_UNDEF;
      else if (load && base_all1)  cls = CLS_LIT;
      else                         cls = CLS_MEM;
   end
endmodule

// File: rtl/cpls_out_stage.sv
module cpls_out_stage #(
   parameter int W         = 8,
   parameter bit ASYNC_RST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         d_valid,
   input  logic [W-1:0] d,
   output logic         q_valid,
   output logic [W-1:0] q
);
   if (ASYNC_RST) begin : g_async
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
         end else begin
            q_valid <= d_valid;
            if (d_valid) q <= d;
         end
      end
   end else begin : g_sync
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            q_valid <= 1'b0;
            q       <= '0;
         end else begin
            q_valid <= d_valid;
            if (d_valid) q <= d;
         end
      end
   end
endmodule

// File: rtl/cpls_classifier.sv
module cpls_classifier
   import cpls_pkg::*;
#(
   parameter int         COND_W     = 4,
   parameter int         REG_W      = 4,
   parameter int         COP_W      = 4,
   parameter int         IMM_W      = 8,
   parameter logic [2:0] GROUP_CODE = 3'b110,
   localparam int        N_COP      = 1 << COP_W,
   parameter logic [N_COP-1:0] RSVD_MASK = 16'h3300,
   parameter logic [N_COP-1:0] VEC_MASK  = 16'h0C00,
   parameter bit         ASYNC_RST  = 1'b0,
   localparam int        INSN_W     = COND_W + 3 + 5 + 2*REG_W + COP_W + IMM_W,
   localparam int        PKT_W      = CLS_W + 8 + 2*REG_W + COP_W + IMM_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [INSN_W-1:0] in_insn,
   output logic              out_valid,
   output logic [CLS_W-1:0]  out_class,
   output logic              out_v2,
   output logic              out_load,
   output logic              out_literal,
   output logic              out_undef,
   output logic              out_pre,
   output logic              out_up,
   output logic              out_long,
   output logic              out_wb,
   output logic [REG_W-1:0]  out_base,
   output logic [REG_W-1:0]  out_creg,
   output logic [COP_W-1:0]  out_cop,
   output logic [IMM_W-1:0]  out_imm
);
   if (COP_W < 1 || COP_W > 6) begin : g_bad_cop
      $error("cpls_classifier: COP_W must be 1..6");
   end
   if (REG_W < 1 || COND_W < 1 || IMM_W < 1) begin : g_bad_w
      $error("cpls_classifier: field widths must be positive");
   end
   if ((RSVD_MASK & VEC_MASK) != '0) begin : g_bad_mask
      $error("cpls_classifier: reserved and vector masks overlap");
   end

   logic             in_group, is_v2, pre, up, lng, wb, load;
   logic [REG_W-1:0] base, creg;
   logic [COP_W-1:0] cop;
   logic [IMM_W-1:0] imm;
   logic             cop_vec, cop_rsvd;
   cpls_cls_e        cls;
   logic             lit_c, undef_c;
   logic [PKT_W-1:0] pkt_d, pkt_q;

   cpls_field_split #(
      .COND_W(COND_W), .REG_W(REG_W), .COP_W(COP_W), .IMM_W(IMM_W),
      .GROUP_CODE(GROUP_CODE)
   ) u_split (
      .insn(in_insn), .in_group(in_group), .is_v2(is_v2),
      .pre(pre), .up(up), .lng(lng), .wb(wb), .load(load),
      .base(base), .creg(creg), .cop(cop), .imm(imm)
   );

   cpls_cop_rules #(
      .COP_W(COP_W), .RSVD_MASK(RSVD_MASK), .VEC_MASK(VEC_MASK)
   ) u_cop (
      .cop(cop), .cop_vec(cop_vec), .cop_rsvd(cop_rsvd)
   );

   cpls_class_pick u_pick (
      .in_group(in_group), .is_v2(is_v2), .pudw({pre, up, lng, wb}),
      .load(load), .base_all1(&base), .cop_vec(cop_vec),
      .cop_rsvd(cop_rsvd), .cls(cls)
   );

   assign lit_c   = (cls == CLS_LIT);
   assign undef_c = (cls == CLS_UNDEF);
   assign pkt_d   = {cls, is_v2, load, lit_c, undef_c, pre, up, lng, wb,
                     base, creg, cop, imm};

   cpls_out_stage #(.W(PKT_W), .ASYNC_RST(ASYNC_RST)) u_reg (
      .clk(clk), .rst_n(rst_n), .d_valid(in_valid), .d(pkt_d),
      .q_valid(out_valid), .q(pkt_q)
   );

   assign {out_class, out_v2, out_load, out_literal, out_undef,
           out_pre, out_up, out_long, out_wb,
           out_base, out_creg, out_cop, out_imm} = pkt_q;
endmodule

// File: rtl/cpls_classifier_chk.sv
module cpls_classifier_chk #(
   parameter int         COND_W     = 4,
   parameter int         REG_W      = 4,
   parameter int         COP_W      = 4,
   parameter int         IMM_W      = 8,
   parameter logic [2:0] GROUP_CODE = 3'b110,
   localparam int        N_COP      = 1 << COP_W,
   parameter logic [N_COP-1:0] RSVD_MASK = 16'h3300,
   parameter logic [N_COP-1:0] VEC_MASK  = 16'h0C00,
   localparam int        INSN_W     = COND_W + 3 + 5 + 2*REG_W + COP_W + IMM_W,
   localparam int        L_BIT      = IMM_W + COP_W + 2*REG_W,
   localparam int        P_BIT      = L_BIT + 4,
   localparam int        GRP_LSB    = P_BIT + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [INSN_W-1:0] in_insn,
   input logic              out_valid,
   input logic [2:0]        out_class,
   input logic              out_load,
   input logic              out_literal,
   input logic              out_undef,
   input logic [REG_W-1:0]  out_base
);
   logic             grp, v2, plain;
   logic [3:0]       pudw;
   logic [COP_W-1:0] cop;

   assign grp   = in_insn[GRP_LSB +: 3] == GROUP_CODE;
   assign v2    = &in_insn[INSN_W-1 -: COND_W];
   assign pudw  = in_insn[P_BIT -: 4];
   assign cop   = in_insn[IMM_W +: COP_W];
   assign plain = grp && pudw != 4'b0000 && pudw != 4'b0010;

   // R1
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R1
   valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R4
   other_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !grp) |=> (out_class == 3'd0 && !out_undef && !out_literal));
   // R5
   pudw_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && grp && pudw == 4'b0000) |=> (out_class == 3'd5 && out_undef));
   // R6
   xfer2_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && grp && pudw == 4'b0010) |=> (out_class == 3'd3));
   // R7
   vec_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && plain && VEC_MASK[cop] && !v2) |=> (out_class == 3'd4 && !out_undef));
   // R7
   vec_v2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && plain && VEC_MASK[cop] && v2) |=> out_undef);
   // R8
   rsvd_cop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && plain && RSVD_MASK[cop]) |=> out_undef);
   // R10
   load_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_load == $past(in_insn[L_BIT])));
   // R9
   literal_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_literal) |-> (out_load && (&out_base) && !out_undef));
endmodule

bind cpls_classifier cpls_classifier_chk #(
   .COND_W(COND_W), .REG_W(REG_W), .COP_W(COP_W), .IMM_W(IMM_W),
   .GROUP_CODE(GROUP_CODE), .RSVD_MASK(RSVD_MASK), .VEC_MASK(VEC_MASK)
) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
   .out_valid(out_valid), .out_class(out_class), .out_load(out_load),
   .out_literal(out_literal), .out_undef(out_undef), .out_base(out_base)
);

// File: tb/cpls_classifier_tb.sv
module cpls_classifier_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] in_insn = '0;
   logic        out_valid;
   logic [2:0]  out_class;
   logic        out_v2, out_load, out_literal, out_undef;
   logic        out_pre, out_up, out_long, out_wb;
   logic [3:0]  out_base, out_creg, out_cop;
   logic [7:0]  out_imm;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk;

   cpls_classifier u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_insn(in_insn),
      .out_valid(out_valid), .out_class(out_class), .out_v2(out_v2),
      .out_load(out_load), .out_literal(out_literal), .out_undef(out_undef),
      .out_pre(out_pre), .out_up(out_up), .out_long(out_long), .out_wb(out_wb),
      .out_base(out_base), .out_creg(out_creg), .out_cop(out_cop),
      .out_imm(out_imm)
   );

   function automatic logic [2:0] exp_cls(input logic [31:0] w);
      logic [3:0] pudw = w[24:21];
      logic [3:0] cp   = w[11:8];
      if (w[27:25] != 3'b110)                        return 3'd0; // R4
      if (pudw == 4'b0000)                           return 3'd5; // R5
      if (pudw == 4'b0010)                           return 3'd3; // R6
      if (cp == 4'd10 || cp == 4'd11)                              // R7
         return (w[31:28] == 4'hF) ? 3'd5 : 3'd4;
      if (cp == 4'd8 || cp == 4'd9 || cp == 4'd12 || cp == 4'd13)
         return 3'd5;                                              // R8
      if (w[20] && w[19:16] == 4'hF)                 return 3'd2; // R9
      return 3'd1;
   endfunction

   task automatic cmp(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [31:0] w, input string req);
      logic [2:0] ec;
      @(negedge clk);
      in_valid = 1'b1;
      in_insn  = w;
      @(negedge clk);
      in_valid = 1'b0;
      ec = exp_cls(w);
      cmp(req, "valid R1", 32'(out_valid), 32'd1);
      cmp(req, "class R12", 32'(out_class), 32'(ec));
      cmp(req, "undef R12", 32'(out_undef), 32'(ec == 3'd5));
      cmp(req, "literal R12", 32'(out_literal), 32'(ec == 3'd2));
      cmp(req, "v2 R3", 32'(out_v2), 32'(w[31:28] == 4'hF));
      cmp(req, "load R10", 32'(out_load), 32'(w[20]));
      cmp(req, "fields R2",
          {8'd0, out_pre, out_up, out_long, out_wb, out_base, out_creg, out_cop, out_imm},
          {8'd0, w[24], w[23], w[22], w[21], w[19:16], w[15:12], w[11:8], w[7:0]});
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         finish_run();
      end
   end

   initial begin
      logic [31:0] w;
      int unsigned seed;
      seed = $urandom(32'h00C0_FFEE);
      repeat (3) @(negedge clk);
      cmp("R1", "valid in reset", 32'(out_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp("R1", "valid after reset", 32'(out_valid), 32'd0);

      // R11 given vector
      apply(32'hFD91_0A01, "R11");
      cmp("R11", "class", 32'(out_class), 32'd5);
      cmp("R11", "undef", 32'(out_undef), 32'd1);
      // R1 valid drops after an idle cycle
      @(negedge clk);
      cmp("R1", "valid idle", 32'(out_valid), 32'd0);
      // R7 conditional form, coproc 10 -> vector/FP redirect
      apply(32'hED91_0A01, "R7");
      cmp("R7", "cond cp10", 32'(out_class), 32'd4);
      apply(32'hFD91_0B01, "R7");
      cmp("R7", "v2 cp11", 32'(out_undef), 32'd1);
      // R5 beats vector rule and literal
      apply(32'hEC1F_0A00, "R5");
      cmp("R5", "pudw zero", 32'(out_class), 32'd5);
      // R6 beats reserved coproc
      apply(32'hFC5F_0800, "R6");
      cmp("R6", "xfer2", 32'(out_class), 32'd3);
      // R8 reserved numbers in both forms
      apply(32'hED91_0C01, "R8");
      cmp("R8", "cp12", 32'(out_undef), 32'd1);
      apply(32'hFD91_0901, "R8");
      cmp("R8", "cp9 v2", 32'(out_undef), 32'd1);
      // R9 literal load, store with base 15
      apply(32'hED9F_5E04, "R9");
      cmp("R9", "literal load", 32'(out_class), 32'd2);
      apply(32'hED8F_5E04, "R9");
      cmp("R9", "store base15", 32'(out_class), 32'd1);
      apply(32'hFD9F_3710, "R9");
      cmp("R9", "v2 literal cp7", 32'(out_literal), 32'd1);
      // R4 other group
      apply(32'hEE91_0A01, "R4");
      cmp("R4", "other", 32'(out_class), 32'd0);
      apply(32'hE59F_0000, "R4");

      // constrained random mix
      for (int i = 0; i < 3000; i++) begin
         w = $urandom;
         if (($urandom % 4) != 0) w[27:25] = 3'b110;
         case ($urandom % 6)
            0: w[24:21] = 4'b0000;
            1: w[24:21] = 4'b0010;
            default: ;
         endcase
         if (($urandom % 3) == 0) w[19:16] = 4'hF;
         if (($urandom % 3) == 0) w[31:28] = 4'hF;
         apply(w, "R2/R12 random");
         if (($urandom % 4) == 0) begin
            @(negedge clk);
            cmp("R1", "valid gap", 32'(out_valid), 32'd0);
         end
      end
      finish_run();
   end
endmodule